// File: doc/BRIEF.md
# MAC Receive Frame Collector

The collector sits on the MAC side of a byte-wide, clock-synchronous PHY link and assembles one received frame at a time. The MAC's own control logic holds `rx_enable` high to listen. A rising edge of `phy_active` starts a frame, and from then on every byte is taken only in cycles where `data_en` is high. Each byte is valid in the same cycle as its strobe. The block walks through a fixed-size physical header, one header status byte, the body (payload with its 32-bit check sequence as the final four octets), and three trailing status bytes. No strobe or flag marks the status bytes, so the block finds them by counting against the 12-bit length carried in the header.

Body bytes leave on a one-byte stream. When the third status byte arrives, a status record is published: rate, length, header and receive error codes, signal strength, link quality, the gathered check sequence, and start and end timestamps. The timestamps come from a free-running cycle counter, sampled on the rising and falling edges of `phy_active`. If the MAC drops `rx_enable` in mid-frame, the stream stops. After a fixed wait the record is closed, taking the last three bytes seen as the status bytes. Any byte that arrives while no frame is open is reported as a stray.

Top module: `mac_rx_collector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all pulse outputs are low, the record fields are zero, and the timestamp counter is zero.
- R2: In the idle state, a cycle where `phy_active` is high after being low in the previous sampled cycle, with `rx_enable` high, opens a frame. `sof` pulses in the next cycle, and `rec_start_ts` takes the counter value of that sampling edge. The counter is 0 at the first edge after reset and advances by one at every edge.
- R3: Only bytes with `data_en` high count. The first `HDR_LEN` of them form the header: octet 0 bits [4:0] give the rate, octet 1 bits [3:0] give length bits [11:8], and octet 2 gives length bits [7:0]. A byte strobed in the opening cycle is header octet 0.
- R4: The byte after the header is the header status byte. Its bits [4:0] are the header error code.
- R5: Exactly `length` body bytes follow. Each one appears on `out_data` with `out_valid` in the cycle after it is taken, and `out_last` marks the final one. `rec_fcs` holds the last four body bytes, with the final byte in bits [31:24] and earlier ones below it. Missing octets are zero.
- R6: The three bytes after the body are, in order, the receive error code (bits [4:0]), the signal strength and the link quality. `rec_valid` pulses in the cycle after the third one, and the record holds all fields.
- R7: When the length is zero, the status bytes follow the header status byte directly. No stream byte is produced, and `rec_fcs` is zero.
- R8: `rec_end_ts` holds the counter value at the most recent falling edge of `phy_active`.
- R9: `rec_bad` is set when the header error or receive error code is non-zero, when the frame was aborted, or when `phy_active` fell before the body was complete.
- R10: If `rx_enable` is low in a cycle while a frame is open (header through status), the frame is aborted, and no stream byte comes from that cycle on. Exactly `ABORT_WAIT` edges later, `rec_valid` pulses with `rec_aborted` set. The status fields come from the last three bytes strobed before that edge, oldest first.
- R11: A byte strobed while idle and not opening a frame raises `stray_byte` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | MAC listen enable; a low level mid-frame aborts |
| phy_active | input | 1 | PHY activity line, frame framing |
| data_en | input | 1 | Byte strobe from the PHY |
| data_in | input | 8 | Received byte |
| sof | output | 1 | Frame opened (one-cycle pulse) |
| out_valid | output | 1 | Body byte on `out_data` |
| out_data | output | 8 | Body byte |
| out_last | output | 1 | Final body byte |
| stray_byte | output | 1 | Byte outside any frame |
| rec_valid | output | 1 | Record complete (one-cycle pulse) |
| rec_rate | output | 5 | Rate code |
| rec_len | output | 12 | Body length in octets |
| rec_hdr_err | output | 5 | Header error code |
| rec_rx_err | output | 5 | Receive error code |
| rec_rssi | output | 8 | Signal strength |
| rec_lqi | output | 8 | Link quality |
| rec_fcs | output | 32 | Last four body octets |
| rec_start_ts | output | TS_W | Timestamp of frame opening |
| rec_end_ts | output | TS_W | Timestamp of last activity fall |
| rec_aborted | output | 1 | Frame ended by MAC abort |
| rec_bad | output | 1 | Frame flagged as errored |

## Verification
The assertions check, on every cycle, the rules that hold for each edge on its own: `sof` is a single pulse that follows an activity rise, a low `rx_enable` or a missing strobe keeps the stream silent in the next cycle, a stray never coincides with stream output, and aborted or header-errored records are flagged bad. Byte counting is covered by the bench scenarios, which compare every cycle against an independent model. These include locating the status bytes for several lengths and strobe spacings, zero-length frames, lengths below four, truncation by an early activity fall, and the abort wait window with its choice of status bytes. Timestamp values are also checked there.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int STAT_BYTES = 3;
    localparam int LEN_W      = 12;
    localparam int RATE_OCT   = 0;
    localparam int LENHI_OCT  = 1;
    localparam int LENLO_OCT  = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_HSTAT,
        PH_BODY,
        PH_TAIL,
        PH_ABORT
    } phase_e;

    typedef struct packed {
        logic [4:0]       rate;
        logic [LEN_W-1:0] len;
        logic [4:0]       hdr_err;
        logic [4:0]       rx_err;
        logic [7:0]       rssi;
        logic [7:0]       lqi;
        logic [31:0]      fcs;
        logic             aborted;
        logic             bad;
    } frame_rec_t;

    function automatic logic open_phase(phase_e p);
        return (p == PH_HDR) || (p == PH_HSTAT) || (p == PH_BODY) || (p == PH_TAIL);
    endfunction

    function automatic logic before_tail(phase_e p);
        return (p == PH_HDR) || (p == PH_HSTAT) || (p == PH_BODY);
    endfunction

    function automatic frame_rec_t seal(frame_rec_t w);
        frame_rec_t r;
        r     = w;
        r.bad = w.bad | (|w.hdr_err) | (|w.rx_err) | w.aborted;
        return r;
    endfunction

endpackage

// File: rtl/rxc_edge_stamp.sv
module rxc_edge_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act,
    output logic            rise,
    output logic            fall,
    output logic [TS_W-1:0] now,
    output logic [TS_W-1:0] fall_ts
);
    logic act_q;

    assign rise = act & ~act_q;
    assign fall = ~act & act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            now     <= '0;
            fall_ts <= '0;
        end else begin
            act_q <= act;
            now   <= now + TS_W'(1);
            if (fall) fall_ts <= now;
        end
    end
endmodule

// File: rtl/rxc_tail_hist.sv
module rxc_tail_hist #(
    parameter int DEPTH = 3,
    parameter int W     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift,
    input  logic [W-1:0]            din,
    output logic [DEPTH-1:0][W-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst)        taps <= '0;
        else if (shift) taps <= {taps[DEPTH-2:0], din};
    end
endmodule

// File: rtl/mac_rx_collector.sv
module mac_rx_collector
    import rxc_pkg::*;
#(
    parameter int HDR_LEN    = 6,
    parameter int ABORT_WAIT = 66,
    parameter int TS_W       = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_enable,
    input  logic            phy_active,
    input  logic            data_en,
    input  logic [7:0]      data_in,
    output logic            sof,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_last,
    output logic            stray_byte,
    output logic            rec_valid,
    output logic [4:0]      rec_rate,
    output logic [11:0]     rec_len,
    output logic [4:0]      rec_hdr_err,
    output logic [4:0]      rec_rx_err,
    output logic [7:0]      rec_rssi,
    output logic [7:0]      rec_lqi,
    output logic [31:0]     rec_fcs,
    output logic [TS_W-1:0] rec_start_ts,
    output logic [TS_W-1:0] rec_end_ts,
    output logic            rec_aborted,
    output logic            rec_bad
);
    localparam int WC_W = $clog2(ABORT_WAIT + 1);
    localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_LEN - 1);
    localparam logic [WC_W-1:0]  WAIT_END = WC_W'(ABORT_WAIT - 1);

    logic            rise, fall;
    logic [TS_W-1:0] now;
    logic [STAT_BYTES-1:0][7:0] taps;

    rxc_edge_stamp #(.TS_W(TS_W)) u_stamp (
        .clk(clk), .rst(rst), .act(phy_active),
        .rise(rise), .fall(fall), .now(now), .fall_ts(rec_end_ts)
    );

    rxc_tail_hist #(.DEPTH(STAT_BYTES), .W(8)) u_hist (
        .clk(clk), .rst(rst), .shift(data_en), .din(data_in), .taps(taps)
    );

    phase_e           phase_q, phase_d, eff;
    logic [LEN_W-1:0] idx_q, idx_d, cidx;
    logic [WC_W-1:0]  wcnt_q, wcnt_d;
    frame_rec_t       work_q, work_d, rec_q, rec_d, tmp;
    logic [TS_W-1:0]  start_q, start_d;
    logic             sof_d, ov_d, last_d, stray_d, rv_d;
    logic [7:0]       od_d;

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        wcnt_d  = wcnt_q;
        work_d  = work_q;
        rec_d   = rec_q;
        start_d = start_q;
        tmp     = work_q;
        sof_d   = 1'b0;
        ov_d    = 1'b0;
        od_d    = out_data;
        last_d  = 1'b0;
        stray_d = 1'b0;
        rv_d    = 1'b0;
        eff     = phase_q;
        cidx    = idx_q;

        if (phase_q == PH_IDLE && rx_enable && rise) begin
            eff     = PH_HDR;
            phase_d = PH_HDR;
            cidx    = '0;
            idx_d   = '0;
            work_d  = '0;
            start_d = now;
            sof_d   = 1'b1;
        end

        if (fall && before_tail(eff)) work_d.bad = 1'b1;

        if (open_phase(eff) && !rx_enable) begin
            phase_d        = PH_ABORT;
            wcnt_d         = '0;
            work_d.aborted = 1'b1;
        end else if (eff == PH_ABORT) begin
            if (wcnt_q == WAIT_END) begin
                tmp        = work_d;
                tmp.rx_err = taps[2][4:0];
                tmp.rssi   = taps[1];
                tmp.lqi    = taps[0];
                rec_d      = seal(tmp);
                rv_d       = 1'b1;
                phase_d    = PH_IDLE;
            end else begin
                wcnt_d = wcnt_q + WC_W'(1);
            end
        end else if (data_en) begin
            case (eff)
                PH_IDLE: stray_d = 1'b1;
                PH_HDR: begin
                    if (cidx == LEN_W'(RATE_OCT))  work_d.rate       = data_in[4:0];
                    if (cidx == LEN_W'(LENHI_OCT)) work_d.len[11:8]  = data_in[3:0];
                    if (cidx == LEN_W'(LENLO_OCT)) work_d.len[7:0]   = data_in;
                    if (cidx == HDR_LAST) begin
                        phase_d = PH_HSTAT;
                        idx_d   = '0;
                    end else begin
                        idx_d = cidx + LEN_W'(1);
                    end
                end
                PH_HSTAT: begin
                    work_d.hdr_err = data_in[4:0];
                    phase_d        = (work_q.len == '0) ? PH_TAIL : PH_BODY;
                    idx_d          = '0;
                end
                PH_BODY: begin
                    ov_d       = 1'b1;
                    od_d       = data_in;
                    work_d.fcs = {data_in, work_q.fcs[31:8]};
                    if (idx_q == work_q.len - LEN_W'(1)) begin
                        last_d  = 1'b1;
                        phase_d = PH_TAIL;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + LEN_W'(1);
                    end
                end
                PH_TAIL: begin
                    if (idx_q == LEN_W'(0))      work_d.rx_err = data_in[4:0];
                    else if (idx_q == LEN_W'(1)) work_d.rssi   = data_in;
                    else                         work_d.lqi    = data_in;
                    if (idx_q == LEN_W'(STAT_BYTES - 1)) begin
                        rec_d   = seal(work_d);
                        rv_d    = 1'b1;
                        phase_d = PH_IDLE;
                    end else begin
                        idx_d = idx_q + LEN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            idx_q      <= '0;
            wcnt_q     <= '0;
            work_q     <= '0;
            rec_q      <= '0;
            start_q    <= '0;
            sof        <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last   <= 1'b0;
            stray_byte <= 1'b0;
            rec_valid  <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            idx_q      <= idx_d;
            wcnt_q     <= wcnt_d;
            work_q     <= work_d;
            rec_q      <= rec_d;
            start_q    <= start_d;
            sof        <= sof_d;
            out_valid  <= ov_d;
            out_data   <= od_d;
            out_last   <= last_d;
            stray_byte <= stray_d;
            rec_valid  <= rv_d;
        end
    end

    assign rec_rate     = rec_q.rate;
    assign rec_len      = rec_q.len;
    assign rec_hdr_err  = rec_q.hdr_err;
    assign rec_rx_err   = rec_q.rx_err;
    assign rec_rssi     = rec_q.rssi;
    assign rec_lqi      = rec_q.lqi;
    assign rec_fcs      = rec_q.fcs;
    assign rec_aborted  = rec_q.aborted;
    assign rec_bad      = rec_q.bad;
    assign rec_start_ts = start_q;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
    input logic        clk,
    input logic        rst,
    input logic        rx_enable,
    input logic        phy_active,
    input logic        data_en,
    input logic        sof,
    input logic        out_valid,
    input logic        out_last,
    input logic        stray_byte,
    input logic        rec_valid,
    input logic [11:0] rec_len,
    input logic [4:0]  rec_hdr_err,
    input logic [31:0] rec_fcs,
    input logic        rec_aborted,
    input logic        rec_bad
);
    assert_sof_single_R2: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);

    assert_sof_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
        sof |-> $past(phy_active) && $past(rx_enable));

    assert_last_in_stream_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_no_strobe_no_out_R5: assert property (@(posedge clk) disable iff (rst)
        !data_en |=> !out_valid);

    assert_zero_len_no_fcs_R7: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_len == 12'd0) |-> rec_fcs == 32'd0);

    assert_abort_is_bad_R9: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_aborted) |-> rec_bad);

    assert_hdr_err_is_bad_R9: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_hdr_err != 5'd0) |-> rec_bad);

    assert_abort_silences_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !out_valid);

    assert_stray_apart_R11: assert property (@(posedge clk) disable iff (rst)
        stray_byte |-> !out_valid && !sof);
endmodule

bind mac_rx_collector rxc_checker u_chk (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .phy_active(phy_active),
    .data_en(data_en), .sof(sof), .out_valid(out_valid), .out_last(out_last),
    .stray_byte(stray_byte), .rec_valid(rec_valid), .rec_len(rec_len),
    .rec_hdr_err(rec_hdr_err), .rec_fcs(rec_fcs), .rec_aborted(rec_aborted),
    .rec_bad(rec_bad)
);

// File: tb/tb_mac_rx_collector.sv
module tb_mac_rx_collector;
    localparam int HDR_LEN = 6;
    localparam int WAITC   = 66;
    localparam int TS_W    = 32;
    localparam int P_IDLE = 0, P_HDR = 1, P_HSTAT = 2, P_BODY = 3, P_TAIL = 4, P_ABORT = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic rx_enable = 1'b0, phy_active = 1'b0, data_en = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic sof, out_valid, out_last, stray_byte, rec_valid, rec_aborted, rec_bad;
    logic [7:0] out_data, rec_rssi, rec_lqi;
    logic [4:0] rec_rate, rec_hdr_err, rec_rx_err;
    logic [11:0] rec_len;
    logic [31:0] rec_fcs;
    logic [TS_W-1:0] rec_start_ts, rec_end_ts;

    mac_rx_collector #(.HDR_LEN(HDR_LEN), .ABORT_WAIT(WAITC), .TS_W(TS_W)) dut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .phy_active(phy_active),
        .data_en(data_en), .data_in(data_in), .sof(sof), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .stray_byte(stray_byte),
        .rec_valid(rec_valid), .rec_rate(rec_rate), .rec_len(rec_len),
        .rec_hdr_err(rec_hdr_err), .rec_rx_err(rec_rx_err), .rec_rssi(rec_rssi),
        .rec_lqi(rec_lqi), .rec_fcs(rec_fcs), .rec_start_ts(rec_start_ts),
        .rec_end_ts(rec_end_ts), .rec_aborted(rec_aborted), .rec_bad(rec_bad)
    );

    always #4 clk = ~clk;

    int n_vec = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference
    int m_phase, m_idx, m_wcnt, m_cnt;
    bit m_paq, m_rise, m_fall;
    int w_rate, w_len, w_herr, w_rxerr, w_rssi, w_lqi;
    bit w_trunc, w_ab;
    byte unsigned body_q[$];
    byte unsigned hist_q[$];
    bit e_sof, e_ov, e_last, e_stray, e_rv;
    int e_od;
    int r_rate, r_len, r_herr, r_rxerr, r_rssi, r_lqi;
    longint r_fcs, e_start, e_end;
    bit r_ab, r_bad;

    task automatic publish();
        longint f;
        int n;
        f = 0;
        n = body_q.size();
        for (int k = 0; k < 4 && k < n; k++)
            f = f | (longint'(body_q[n-1-k]) << (24 - 8*k));
        r_rate = w_rate; r_len = w_len; r_herr = w_herr; r_rxerr = w_rxerr;
        r_rssi = w_rssi; r_lqi = w_lqi; r_fcs = f; r_ab = w_ab;
        r_bad = w_trunc || w_ab || (w_herr != 0) || (w_rxerr != 0);
        e_rv = 1'b1;
        m_phase = P_IDLE;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = P_IDLE; m_idx = 0; m_wcnt = 0; m_cnt = 0; m_paq = 0;
            e_sof = 0; e_ov = 0; e_last = 0; e_stray = 0; e_rv = 0; e_od = 0;
            hist_q = '{8'h00, 8'h00, 8'h00};
            body_q.delete();
            e_start = 0; e_end = 0;
        end else begin
            m_rise = phy_active && !m_paq;
            m_fall = !phy_active && m_paq;
            e_sof = 0; e_ov = 0; e_last = 0; e_stray = 0; e_rv = 0;
            if (m_phase == P_IDLE && rx_enable && m_rise) begin
                m_phase = P_HDR; m_idx = 0;
                w_rate = 0; w_len = 0; w_herr = 0; w_rxerr = 0; w_rssi = 0; w_lqi = 0;
                w_trunc = 0; w_ab = 0;
                body_q.delete();
                e_start = m_cnt; e_sof = 1;
            end
            if (m_fall) begin
                e_end = m_cnt;
                if (m_phase == P_HDR || m_phase == P_HSTAT || m_phase == P_BODY) w_trunc = 1;
            end
            if (m_phase >= P_HDR && m_phase <= P_TAIL && !rx_enable) begin
                m_phase = P_ABORT; m_wcnt = 0; w_ab = 1;
            end else if (m_phase == P_ABORT) begin
                if (m_wcnt == WAITC - 1) begin
                    w_rxerr = hist_q[0] & 31;
                    w_rssi  = hist_q[1];
                    w_lqi   = hist_q[2];
                    publish();
                end else m_wcnt++;
            end else if (data_en) begin
                case (m_phase)
                    P_IDLE: e_stray = 1;
                    P_HDR: begin
                        if (m_idx == 0) w_rate = data_in & 31;
                        if (m_idx == 1) w_len = (w_len & 255) | ((data_in & 15) << 8);
                        if (m_idx == 2) w_len = (w_len & 'hF00) | data_in;
                        if (m_idx == HDR_LEN - 1) begin m_phase = P_HSTAT; m_idx = 0; end
                        else m_idx++;
                    end
                    P_HSTAT: begin
                        w_herr = data_in & 31;
                        m_phase = (w_len == 0) ? P_TAIL : P_BODY;
                        m_idx = 0;
                    end
                    P_BODY: begin
                        e_ov = 1; e_od = data_in;
                        body_q.push_back(data_in);
                        if (body_q.size() == w_len) begin e_last = 1; m_phase = P_TAIL; m_idx = 0; end
                    end
                    P_TAIL: begin
                        if (m_idx == 0) w_rxerr = data_in & 31;
                        else if (m_idx == 1) w_rssi = data_in;
                        else w_lqi = data_in;
                        if (m_idx == 2) publish();
                        else m_idx++;
                    end
                    default: ;
                endcase
            end
            if (data_en) begin
                hist_q.push_back(data_in);
                void'(hist_q.pop_front());
            end
            m_cnt++;
            m_paq = phy_active;
        end
    end

    int ov_seen = 0;
    bit last_ab = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) ov_seen++;
            if (rec_valid) last_ab = rec_aborted;
            chk(sof == e_sof, "R2", "sof", sof, e_sof);
            chk(out_valid == e_ov, "R5", "out_valid", out_valid, e_ov);
            if (e_ov) chk(out_data == e_od[7:0], "R5", "out_data", out_data, e_od);
            chk(out_last == e_last, "R5", "out_last", out_last, e_last);
            chk(stray_byte == e_stray, "R11", "stray_byte", stray_byte, e_stray);
            chk(rec_valid == e_rv, "R6", "rec_valid", rec_valid, e_rv);
            if (e_rv) begin
                chk(rec_rate == r_rate[4:0], "R3", "rate", rec_rate, r_rate);
                chk(rec_len == r_len[11:0], "R3", "len", rec_len, r_len);
                chk(rec_hdr_err == r_herr[4:0], "R4", "hdr_err", rec_hdr_err, r_herr);
                chk(rec_rx_err == r_rxerr[4:0], "R6", "rx_err", rec_rx_err, r_rxerr);
                chk(rec_rssi == r_rssi[7:0], "R6", "rssi", rec_rssi, r_rssi);
                chk(rec_lqi == r_lqi[7:0], "R6", "lqi", rec_lqi, r_lqi);
                chk(longint'(rec_fcs) == r_fcs, "R5", "fcs", rec_fcs, r_fcs);
                chk(longint'(rec_start_ts) == e_start, "R2", "start_ts", rec_start_ts, e_start);
                chk(longint'(rec_end_ts) == e_end, "R8", "end_ts", rec_end_ts, e_end);
                chk(rec_bad == r_bad, "R9", "bad", rec_bad, r_bad);
                chk(rec_aborted == r_ab, "R10", "aborted", rec_aborted, r_ab);
            end
        end
    end

    task automatic put(input logic [7:0] b, input int gap);
        data_en = 1'b0;
        repeat (gap) @(negedge clk);
        data_en = 1'b1;
        data_in = b;
        @(negedge clk);
        data_en = 1'b0;
    endtask

    task automatic send_frame(input int rate, input int len, input int herr, input int rxerr,
                              input int rssi, input int lqi, input int gap, input int trunc_at);
        phy_active = 1'b1;
        for (int i = 0; i < HDR_LEN; i++) begin
            logic [7:0] b;
            if (i == 0)      b = 8'(8'hE0 | rate);
            else if (i == 1) b = 8'(8'hA0 | ((len >> 8) & 15));
            else if (i == 2) b = 8'(len & 255);
            else             b = 8'(8'h30 + i);
            put(b, (i % (gap + 1)));
        end
        put(8'(8'hE0 | herr), gap);
        for (int i = 0; i < len; i++) begin
            if (i == trunc_at) phy_active = 1'b0;
            put(8'(8'h17 * i + rate), (i % (gap + 1)));
        end
        @(negedge clk);
        phy_active = 1'b0;
        repeat (2) @(negedge clk);
        put(8'(8'hC0 | rxerr), gap);
        put(8'(rssi), 0);
        put(8'(lqi), gap);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet and record cleared while in reset
        chk(!sof && !out_valid && !stray_byte && !rec_valid, "R1", "pulses in reset",
            {sof, out_valid, stray_byte, rec_valid}, 0);
        chk(rec_len == 0 && rec_fcs == 0 && !rec_bad, "R1", "record in reset", rec_fcs, 0);
        chk(rec_start_ts == 0 && rec_end_ts == 0, "R1", "timestamps in reset", rec_end_ts, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sof && !rec_valid && rec_len == 0, "R1", "first cycle after reset", rec_len, 0);

        // R11: stray bytes, listening and not
        put(8'h55, 1);
        rx_enable = 1'b1;
        put(8'hAA, 2);
        repeat (2) @(negedge clk);

        // R3 R5 R6 R8: normal frames with varied spacing
        send_frame(5'd9, 6, 0, 0, 8'h40, 8'h7F, 0, -1);
        send_frame(5'd3, 17, 0, 0, 8'h21, 8'h88, 2, -1);
        send_frame(5'd1, 1, 0, 0, 8'h01, 8'h02, 1, -1);

        // R7: zero-length frame, no stream bytes
        ov_seen = 0;
        send_frame(5'd4, 0, 0, 0, 8'h33, 8'h44, 1, -1);
        chk(ov_seen == 0, "R7", "stream bytes in zero-length frame", ov_seen, 0);

        // R4 R9: header error; receive error with pad bytes
        send_frame(5'd2, 5, 5'h11, 0, 8'h10, 8'h20, 0, -1);
        send_frame(5'd7, 9, 0, 5'h1F, 8'h90, 8'hA0, 1, -1);

        // R9: activity drops mid-body
        send_frame(5'd6, 8, 0, 0, 8'h55, 8'h66, 0, 2);

        // R11: stray after the last status byte
        put(8'hEE, 0);
        repeat (2) @(negedge clk);

        // R10: MAC abort in the body
        last_ab = 0;
        phy_active = 1'b1;
        for (int i = 0; i < HDR_LEN; i++)
            put((i == 2) ? 8'd20 : 8'(i + 1), 0);
        put(8'h00, 0);
        for (int i = 0; i < 5; i++) put(8'(8'h60 + i), 1);
        rx_enable = 1'b0;
        repeat (3) @(negedge clk);
        phy_active = 1'b0;
        put(8'h0B, 1);
        put(8'hB2, 0);
        put(8'hC3, 2);
        repeat (WAITC + 5) @(negedge clk);
        chk(last_ab == 1'b1, "R10", "aborted record seen", last_ab, 1);
        rx_enable = 1'b1;
        repeat (2) @(negedge clk);

        // R10: abort inside the header, fewer than three new bytes
        phy_active = 1'b1;
        put(8'h05, 0);
        rx_enable = 1'b0;
        @(negedge clk);
        phy_active = 1'b0;
        repeat (WAITC + 4) @(negedge clk);
        rx_enable = 1'b1;
        repeat (2) @(negedge clk);

        // R2: frame after recovery
        send_frame(5'd12, 3, 0, 0, 8'h0A, 8'h0B, 0, -1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule